// File: doc/BRIEF.md
# Two-Input Handshake Mixer

This block joins two passive four-phase handshake ports, `a` and `b`, onto a single active four-phase port `c`. A request arriving on either input produces one complete request/acknowledge/return-to-zero handshake on `c`. The acknowledge from `c` is passed back only to the input that opened the cycle. The block carries no data and does no arbitration. The environment promises that `a_req` and `b_req` are never high together. The block flags a broken promise on an error output and otherwise ignores it.

The block is modelled as a clocked state machine. At the start of a cycle it records which input owns that cycle. It keeps that ownership until the return-to-zero phase on `c` has completed, so a request from the other side is held off until then. All handshake outputs are decoded from registered state and owner, so each output moves exactly one clock after the input event that causes it.

Top module: `hs_mixer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `c_req`, `a_ack`, `b_ack` and `mix_err` are all low.
- R2: When idle, a request on `a` alone (a_req=1, b_req=0) sampled at a clock edge makes `c_req` high after that edge, and port `a` becomes the owner.
- R3: While `c_req` is high and the owner's acknowledge is low, `c_ack` sampled high makes the owner's acknowledge go high after that edge. The other input's acknowledge stays low.
- R4: While the owner's acknowledge is high, the owner's request sampled low makes `c_req` go low after that edge. `c_req` stays high for as long as the owner's request stays high.
- R5: After `c_req` has dropped, `c_ack` sampled low makes the owner's acknowledge go low after that edge, and the block is then idle.
- R6: Port `b` follows the same mapping as R2 to R5, using `b_req` and `b_ack`.
- R7: `a_ack` and `b_ack` are never high together. An input that did not open the current cycle never sees its acknowledge rise, even while `c_ack` is high.
- R8: If both requests are sampled high while idle, no cycle starts and `c_req` stays low. `mix_err` is high for exactly one clock after the first edge at which both requests are seen high together.
- R9: A request from the non-owner that arrives after the owner's request has dropped, but before `c_ack` has fallen, does not raise `c_req`. It is served by a new cycle that starts on the edge after the block returns to idle.
- R10: `c_ack` going high while the block is idle raises no acknowledge and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Request from input port a |
| a_ack | output | 1 | Acknowledge to input port a |
| b_req | input | 1 | Request from input port b |
| b_ack | output | 1 | Acknowledge to input port b |
| c_req | output | 1 | Request on the merged output port |
| c_ack | input | 1 | Acknowledge from the merged output port |
| mix_err | output | 1 | One-clock pulse when both requests are seen high together |

## Verification
The hardest case to reach from the ports is a legal, non-overlapping request from the second input that lands inside the first input's return-to-zero window. In that window the first request has already fallen but `c_ack` is still high. A simple alternating stimulus never reaches this window, because it always waits for the previous acknowledge to fall first. A directed test therefore holds `c_ack` high on purpose after the owner's request drops, raises `b_req` in that window, and counts the cycles until `c_req` rises again. Table-driven and random handshakes with varying `c_ack` delays cover the routing of acknowledges for both inputs.

// File: rtl/mix_pkg.sv
package mix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HELD = 2'd2,
    ST_RTZ  = 2'd3
  } mix_st_e;

  typedef enum logic {
    OWN_A = 1'b0,
    OWN_B = 1'b1
  } mix_own_e;

  // exactly one input requesting: a legal start condition
  function automatic logic single_req(input logic ra, input logic rb);
    return ra ^ rb;
  endfunction

  // request level of the port that owns the cycle
  function automatic logic owner_req(input mix_own_e own, input logic ra, input logic rb);
    return (own == OWN_B) ? rb : ra;
  endfunction

  // acknowledge phase spans the held and return-to-zero states
  function automatic logic ack_phase(input mix_st_e st);
    return (st == ST_HELD) || (st == ST_RTZ);
  endfunction

  function automatic logic req_phase(input mix_st_e st);
    return (st == ST_REQ) || (st == ST_HELD);
  endfunction

endpackage

// File: rtl/mix_fsm.sv
module mix_fsm
  import mix_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     a_req,
  input  logic     b_req,
  input  logic     c_ack,
  output mix_st_e  state,
  output mix_own_e owner,
  output logic     start_ev,
  output logic     done_ev
);
  mix_st_e  st_q, st_d;
  mix_own_e own_q, own_d;

  always_comb begin
    st_d     = st_q;
    own_d    = own_q;
    start_ev = 1'b0;
    done_ev  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (single_req(a_req, b_req)) begin
        st_d     = ST_REQ;
        own_d    = b_req ? OWN_B : OWN_A;
        start_ev = 1'b1;
      end
      ST_REQ:  if (c_ack) st_d = ST_HELD;
      ST_HELD: if (!owner_req(own_q, a_req, b_req)) st_d = ST_RTZ;
      ST_RTZ:  if (!c_ack) begin
        st_d    = ST_IDLE;
        done_ev = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      own_q <= OWN_A;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  assign state = st_q;
  assign owner = own_q;
endmodule

// File: rtl/mix_route.sv
module mix_route
  import mix_pkg::*;
(
  input  mix_st_e  state,
  input  mix_own_e owner,
  output logic     c_req,
  output logic     a_ack,
  output logic     b_ack
);
  logic ack_on;

  assign ack_on = ack_phase(state);
  assign c_req  = req_phase(state);
  assign a_ack  = ack_on && (owner == OWN_A);
  assign b_ack  = ack_on && (owner == OWN_B);
endmodule

// File: rtl/mix_clash.sv
module mix_clash (
  input  logic clk,
  input  logic rst_n,
  input  logic a_req,
  input  logic b_req,
  output logic err
);
  logic both, both_q, err_q;

  assign both = a_req && b_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      both_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      both_q <= both;
      err_q  <= both && !both_q;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/hs_mixer.sv
module hs_mixer
  import mix_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_req,
  output logic a_ack,
  input  logic b_req,
  output logic b_ack,
  output logic c_req,
  input  logic c_ack,
  output logic mix_err
);
  mix_st_e  state;
  mix_own_e owner;
  logic     start_ev, done_ev;

  mix_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .b_req(b_req), .c_ack(c_ack),
    .state(state), .owner(owner), .start_ev(start_ev), .done_ev(done_ev)
  );

  mix_route u_route (
    .state(state), .owner(owner), .c_req(c_req), .a_ack(a_ack), .b_ack(b_ack)
  );

  mix_clash u_clash (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .b_req(b_req), .err(mix_err)
  );
endmodule

// File: rtl/mix_sva.sv
module mix_sva (
  input logic clk,
  input logic rst_n,
  input logic a_req,
  input logic a_ack,
  input logic b_req,
  input logic b_ack,
  input logic c_req,
  input logic c_ack,
  input logic mix_err,
  input logic start_ev,
  input logic done_ev
);
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ack && b_ack)); // R7
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_req) |-> ($past(a_req) ^ $past(b_req))); // R2
  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_req) |-> (!$past(a_ack) && !$past(b_ack))); // R9
  AST_A_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ack) |-> ($past(c_ack) && $past(c_req) && c_req)); // R3
  AST_B_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_ack) |-> ($past(c_ack) && $past(c_req) && c_req)); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c_req) |-> (($past(a_ack) && !$past(a_req)) || ($past(b_ack) && !$past(b_req)))); // R4
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(a_ack) || $fell(b_ack)) |-> (!$past(c_ack) && !c_req)); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mix_err |-> $past(a_req && b_req)); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mix_err |=> !mix_err); // R8
  AST_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && done_ev)); // R9
endmodule

bind hs_mixer mix_sva u_sva (
  .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_ack(a_ack), .b_req(b_req),
  .b_ack(b_ack), .c_req(c_req), .c_ack(c_ack), .mix_err(mix_err),
  .start_ev(start_ev), .done_ev(done_ev)
);

// File: tb/sim_hs_mixer.sv
module sim_hs_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_req = 1'b0, b_req = 1'b0, c_ack = 1'b0;
  logic a_ack, b_ack, c_req, mix_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  hs_mixer u0 (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .a_ack(a_ack), .b_req(b_req),
    .b_ack(b_ack), .c_req(c_req), .c_ack(c_ack), .mix_err(mix_err)
  );

  // entry: {use_b, c_ack delay[2:0], release delay[2:0]}
  localparam logic [6:0] VEC [16] = '{
    7'b0_000_000, 7'b1_000_000, 7'b0_001_010, 7'b1_010_001,
    7'b0_111_000, 7'b1_000_111, 7'b1_011_011, 7'b0_100_001,
    7'b0_000_000, 7'b0_010_010, 7'b1_001_000, 7'b1_001_000,
    7'b0_101_110, 7'b1_110_101, 7'b0_011_000, 7'b1_000_011
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input logic use_b, input logic v);
    if (use_b) b_req = v; else a_req = v;
  endtask

  // full handshake from one side with the c side answering
  task automatic cycle(input logic use_b, input int d_ack, input int d_rel);
    set_req(use_b, 1'b1);
    step();
    chk(use_b ? "R6 c_req up" : "R2 c_req up", c_req, 1'b1);
    chk("R7 no early ack", a_ack | b_ack, 1'b0);
    for (int i = 0; i < d_ack; i++) begin
      step();
      chk("R3 c_req held", c_req, 1'b1);
      chk("R3 no ack yet", a_ack | b_ack, 1'b0);
    end
    c_ack = 1'b1;
    step();
    chk(use_b ? "R6 b_ack up" : "R3 a_ack up", use_b ? b_ack : a_ack, 1'b1);
    chk("R7 other ack low", use_b ? a_ack : b_ack, 1'b0);
    for (int i = 0; i < d_rel; i++) begin
      step();
      chk("R4 c_req held while req", c_req, 1'b1);
    end
    set_req(use_b, 1'b0);
    step();
    chk(use_b ? "R6 c_req down" : "R4 c_req down", c_req, 1'b0);
    chk("R7 owner ack still high", use_b ? b_ack : a_ack, 1'b1);
    c_ack = 1'b0;
    step();
    chk(use_b ? "R6 b_ack down" : "R5 a_ack down", a_ack | b_ack, 1'b0);
    chk("R5 idle c_req", c_req, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 c_req in reset", c_req, 1'b0);
    chk("R1 acks in reset", a_ack | b_ack, 1'b0);
    chk("R1 err in reset", mix_err, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 c_req after reset", c_req, 1'b0);
    chk("R1 err after reset", mix_err, 1'b0);

    foreach (VEC[i]) cycle(VEC[i][6], int'(VEC[i][5:3]), int'(VEC[i][2:0]));

    for (int k = 0; k < 40; k++) cycle(1'($urandom_range(1)), $urandom_range(5), $urandom_range(5));

    // R10: stray c_ack while idle
    c_ack = 1'b1;
    step();
    step();
    chk("R10 no ack from idle c_ack", a_ack | b_ack, 1'b0);
    chk("R10 no c_req from idle c_ack", c_req, 1'b0);
    c_ack = 1'b0;
    step();

    // R8: overlap while idle
    a_req = 1'b1; b_req = 1'b1;
    step();
    chk("R8 err pulse", mix_err, 1'b1);
    chk("R8 no start", c_req, 1'b0);
    step();
    chk("R8 err one clock", mix_err, 1'b0);
    chk("R8 still no start", c_req, 1'b0);
    a_req = 1'b0; b_req = 1'b0;
    step();
    chk("R8 no start after clear", c_req, 1'b0);

    // R9: b requests inside a's return-to-zero window
    a_req = 1'b1;
    step();
    c_ack = 1'b1;
    step();
    chk("R9 a_ack up", a_ack, 1'b1);
    a_req = 1'b0;
    step();
    chk("R9 c_req down", c_req, 1'b0);
    b_req = 1'b1;
    step();
    step();
    chk("R9 b held off", c_req, 1'b0);
    chk("R9 b_ack low", b_ack, 1'b0);
    chk("R9 a_ack still high", a_ack, 1'b1);
    c_ack = 1'b0;
    step();
    chk("R9 a_ack down", a_ack, 1'b0);
    chk("R9 c_req not yet", c_req, 1'b0);
    step();
    chk("R9 b served", c_req, 1'b1);
    c_ack = 1'b1;
    step();
    chk("R9 b_ack up", b_ack, 1'b1);
    chk("R9 a_ack stays low", a_ack, 1'b0);
    b_req = 1'b0;
    step();
    c_ack = 1'b0;
    step();
    chk("R9 back idle", b_ack | c_req, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule